// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block sequences the digital side of a switched-capacitor successive approximation converter. A start pulse, taken only while the block is idle, captures a channel index and a resolution choice (10 or 8 bits). The block then spends a fixed number of cycles acquiring the input, with the capacitor array held at code zero. After that it performs one bit trial per cycle from the most significant bit down. For each trial it drives a code to the array and uses the single comparator bit to decide whether the bit under test stays set.

When the last trial is decided, the result is written into a per-channel result store and `done` pulses for one cycle. A 10-bit result is split across two byte registers per channel. An 8-bit result fits in one byte, so a single read returns all of it. A registered byte-wide read port gives access to any result register at any time.

Top module: `sar_conv_ctrl`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `busy`, `done`, `trial_code` and `rd_data` are zero. A reset during a conversion abandons it.
- R2: A `start` seen at a clock edge while idle raises `busy` from the next cycle. `busy` stays high for exactly 14 cycles in 10-bit mode (`res10`=1) and exactly 12 cycles in 8-bit mode (`res10`=0).
- R3: `done` is high for exactly one cycle, the cycle right after `busy` falls, and it is never high together with `busy`.
- R4: `trial_code` is zero during the first 4 busy cycles, the acquisition phase. On the 5th busy cycle it equals 512, the first trial with only bit 9 set.
- R5: Each trial keeps the bit under test when `cmp_in` is 1 (input at or above the trial code) and clears it otherwise. With a comparator that reports input >= code, the 10-bit result equals the input. In the cycle `done` is high, `trial_code` holds the final code.
- R6: A 10-bit result is stored for its channel as register 0 = {6'b0, result[9:8]} and register 1 = result[7:0].
- R7: In 8-bit mode the trials use `trial_code` bits 9..2, with bits 1..0 kept zero. The 8-bit result (bits 9..2 of the final code) is written to register 0 of the channel, and register 1 of that channel keeps its previous contents.
- R8: A `start` that arrives while `busy` is high is ignored. It does not change the timing, the target channel or the result.
- R9: The read port is registered. `rd_data` shows, one cycle later, the register chosen by `rd_ch` and `rd_sel` (0 selects register 0, 1 selects register 1) at the previous edge.
- R10: The channel and resolution are captured at the accepted start. Changes on `ch_sel` and `res10` during a conversion have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion request |
| res10 | input | 1 | 1 = 10-bit, 0 = 8-bit resolution |
| ch_sel | input | 3 | Channel that receives the result |
| cmp_in | input | 1 | Comparator: 1 when input >= trial code |
| rd_ch | input | 3 | Read channel |
| rd_sel | input | 1 | Read register select within the channel |
| trial_code | output | 10 | Code driven to the capacitor array |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Registered read data |

## Verification
The bench counts busy cycles in both resolutions. An off-by-one in the cycle budget, or a wrong choice between the two budgets, shows up as a wrong count. It also watches for the first trial code after exactly four acquisition cycles. Every conversion carries a start pulse part-way through, with the channel and resolution inputs flipped at the same time. A design that relaunches, or that samples those inputs late, ends up with a wrong busy length or writes its result to the wrong channel. Input values at both ends of the range and alternating bit patterns test the keep-or-clear rule. After each 8-bit conversion the bench reads register 1 of the channel, which catches a design that overwrites or shifts the other byte of the pair.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACQ   = 2'd1,
    ST_TRIAL = 2'd2
  } sar_state_t;
endpackage

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int ACQ_CYC = 4,
  parameter int HI_BITS = 10,
  parameter int LO_BITS = 8,
  parameter int CH_W    = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            res10,
  input  logic [CH_W-1:0] ch_sel,
  output logic            busy,
  output logic            done,
  output logic            launch,
  output logic            arm,
  output logic            step,
  output logic            fin,
  output logic            res_q,
  output logic [CH_W-1:0] ch_q
);
  import sar_pkg::*;

  localparam int CNT_W    = $clog2(ACQ_CYC + HI_BITS + 1);
  localparam int LAST_HI  = ACQ_CYC + HI_BITS - 1;
  localparam int LAST_LO  = ACQ_CYC + LO_BITS - 1;

  sar_state_t       st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_cnt;

  always_comb begin
    last_cnt = res_q ? CNT_W'(LAST_HI) : CNT_W'(LAST_LO);
    launch   = (st == ST_IDLE) && start;
    arm      = (st == ST_ACQ) && (cnt == CNT_W'(ACQ_CYC - 1));
    step     = (st == ST_TRIAL);
    fin      = step && (cnt == last_cnt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
      res_q <= 1'b0;
      ch_q  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          st    <= ST_ACQ;
          cnt   <= '0;
          busy  <= 1'b1;
          res_q <= res10;
          ch_q  <= ch_sel;
        end
        ST_ACQ: begin
          cnt <= cnt + 1'b1;
          if (arm) st <= ST_TRIAL;
        end
        ST_TRIAL: begin
          cnt <= cnt + 1'b1;
          if (fin) begin
            st   <= ST_IDLE;
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R3
  done_excl_chk: assert property (@(posedge clk) disable iff (rst) !(busy && done));
  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> $past(start));
  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !fin) |=> (busy && $stable(ch_q) && $stable(res_q)));
endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
  parameter int HI_BITS = 10,
  parameter int LO_BITS = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               launch,
  input  logic               arm,
  input  logic               step,
  input  logic               fin,
  input  logic               res_q,
  input  logic               cmp_in,
  output logic [HI_BITS-1:0] code,
  output logic [HI_BITS-1:0] result
);
  localparam int GAP = HI_BITS - LO_BITS;
  localparam logic [HI_BITS-1:0] MSB = {1'b1, {(HI_BITS-1){1'b0}}};

  logic [HI_BITS-1:0] mask;

  always_comb result = cmp_in ? code : (code & ~mask);

  always_ff @(posedge clk) begin
    if (rst || launch) begin
      code <= '0;
      mask <= '0;
    end else if (arm) begin
      code <= MSB;
      mask <= MSB;
    end else if (step) begin
      mask <= mask >> 1;
      code <= fin ? result : (result | (mask >> 1));
    end
  end

  // R5
  trial_onehot_chk: assert property (@(posedge clk) disable iff (rst) step |-> $onehot(mask));
  // R7
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !res_q) |-> (code[GAP-1:0] == '0));
endmodule

// File: rtl/sar_regfile.sv
module sar_regfile #(
  parameter int NUM_CH  = 8,
  parameter int HI_BITS = 10,
  parameter int LO_BITS = 8,
  parameter int CH_W    = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               wr_res10,
  input  logic [CH_W-1:0]    wr_ch,
  input  logic [HI_BITS-1:0] wr_val,
  input  logic [CH_W-1:0]    rd_ch,
  input  logic               rd_sel,
  output logic [LO_BITS-1:0] rd_data
);
  localparam int GAP = HI_BITS - LO_BITS;

  logic [LO_BITS-1:0] mem0 [NUM_CH];
  logic [LO_BITS-1:0] mem1 [NUM_CH];
  logic [LO_BITS-1:0] w0;

  always_comb begin
    w0 = '0;
    if (wr_res10) w0[GAP-1:0] = wr_val[HI_BITS-1:LO_BITS];
    else          w0 = wr_val[HI_BITS-1:GAP];
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem0[wr_ch] <= w0;
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_res10) mem1[wr_ch] <= wr_val[LO_BITS-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_sel ? mem1[rd_ch] : mem0[rd_ch];
  end

  // R6
  hi_pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_res10) |=> (mem0[$past(wr_ch)][LO_BITS-1:GAP] == '0));
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int NUM_CH  = 8,
  parameter int HI_BITS = 10,
  parameter int LO_BITS = 8,
  parameter int ACQ_CYC = 4,
  parameter int CH_W    = $clog2(NUM_CH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               res10,
  input  logic [CH_W-1:0]    ch_sel,
  input  logic               cmp_in,
  input  logic [CH_W-1:0]    rd_ch,
  input  logic               rd_sel,
  output logic [HI_BITS-1:0] trial_code,
  output logic               busy,
  output logic               done,
  output logic [LO_BITS-1:0] rd_data
);
  logic            launch, arm, step, fin, res_q;
  logic [CH_W-1:0] ch_q;
  logic [HI_BITS-1:0] result;

  sar_seq #(.ACQ_CYC(ACQ_CYC), .HI_BITS(HI_BITS), .LO_BITS(LO_BITS), .CH_W(CH_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .res10(res10), .ch_sel(ch_sel),
    .busy(busy), .done(done), .launch(launch), .arm(arm), .step(step),
    .fin(fin), .res_q(res_q), .ch_q(ch_q)
  );

  sar_approx #(.HI_BITS(HI_BITS), .LO_BITS(LO_BITS)) u_approx (
    .clk(clk), .rst(rst), .launch(launch), .arm(arm), .step(step), .fin(fin),
    .res_q(res_q), .cmp_in(cmp_in), .code(trial_code), .result(result)
  );

  sar_regfile #(.NUM_CH(NUM_CH), .HI_BITS(HI_BITS), .LO_BITS(LO_BITS), .CH_W(CH_W)) u_rf (
    .clk(clk), .rst(rst), .wr_en(fin), .wr_res10(res_q), .wr_ch(ch_q),
    .wr_val(result), .rd_ch(rd_ch), .rd_sel(rd_sel), .rd_data(rd_data)
  );
endmodule

// File: tb/sar_conv_ctrl_tb.sv
module sar_conv_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       res10 = 1'b1;
  logic [2:0] ch_sel = '0;
  logic       cmp_in;
  logic [2:0] rd_ch = '0;
  logic       rd_sel = 1'b0;
  logic [9:0] trial_code;
  logic       busy, done;
  logic [7:0] rd_data;
  logic [9:0] vin = '0;

  int checks = 0;
  int fails  = 0;
  logic [7:0] sh1 [8];

  always #2 clk = ~clk;
  assign cmp_in = (vin >= trial_code);

  sar_conv_ctrl u_dut (
    .clk(clk), .rst(rst), .start(start), .res10(res10), .ch_sel(ch_sel),
    .cmp_in(cmp_in), .rd_ch(rd_ch), .rd_sel(rd_sel), .trial_code(trial_code),
    .busy(busy), .done(done), .rd_data(rd_data)
  );

  // {res10, channel, input value}
  localparam logic [13:0] VEC [12] = '{
    {1'b1, 3'd0, 10'h000}, {1'b1, 3'd1, 10'h3FF}, {1'b1, 3'd2, 10'h200},
    {1'b1, 3'd3, 10'h1FF}, {1'b0, 3'd0, 10'h3FF}, {1'b0, 3'd1, 10'h155},
    {1'b1, 3'd4, 10'h2AA}, {1'b0, 3'd4, 10'h001}, {1'b0, 3'd2, 10'h003},
    {1'b1, 3'd7, 10'h0C5}, {1'b0, 3'd3, 10'h0FE}, {1'b1, 3'd5, 10'h301}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] c, input logic s, output logic [7:0] d);
    @(negedge clk); rd_ch = c; rd_sel = s;
    @(negedge clk); d = rd_data;
  endtask

  task automatic convert(input logic r, input logic [2:0] c, input logic [9:0] v);
    int n;
    int budget;
    logic [9:0] fcode;
    logic [7:0] d;
    budget = r ? 14 : 12;
    fcode  = r ? v : {v[9:2], 2'b00};
    @(negedge clk); res10 = r; ch_sel = c; vin = v; start = 1'b1;
    @(negedge clk); start = 1'b0; n = 0;
    while (busy && n < 40) begin
      n++;
      if (n == 4) chk(trial_code == 10'd0, "R4 acquire code", trial_code, 0);
      if (n == 5) chk(trial_code == 10'd512, "R4 first trial", trial_code, 512);
      if (n == 7 && !r) chk(trial_code[1:0] == 2'b00, "R7 low bits", trial_code[1:0], 0);
      if (n == 6) begin start = 1'b1; res10 = ~r; ch_sel = ~c; end // R8 R10
      if (n == 7) start = 1'b0;
      @(negedge clk);
    end
    chk(n == budget, "R2 busy length", n, budget);
    chk(done == 1'b1, "R3 done after busy", done, 1);
    chk(trial_code == fcode, "R5 final code", trial_code, fcode);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R3 done one cycle R8 no relaunch", {busy, done}, 0);
    res10 = r; ch_sel = c;
    rd(c, 1'b0, d);
    if (r) chk(d == {6'b0, v[9:8]}, "R6 register 0", d, {6'b0, v[9:8]});
    else   chk(d == v[9:2], "R7 register 0", d, v[9:2]);
    rd(c, 1'b1, d);
    if (r) begin
      chk(d == v[7:0], "R6 register 1", d, v[7:0]);
      sh1[c] = v[7:0];
    end else chk(d == sh1[c], "R7 register 1 kept", d, sh1[c]);
    rd(~c, 1'b0, d); // R10: flipped channel must not have received this result
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && trial_code == 0, "R1 reset outputs", {busy, done, trial_code}, 0);
    chk(rd_data == 0, "R1 reset read", rd_data, 0);
    rst = 1'b0;
    foreach (VEC[i]) convert(VEC[i][13], VEC[i][12:10], VEC[i][9:0]);
    // R9: read latency, address changes every cycle
    @(negedge clk); rd_ch = 3'd1; rd_sel = 1'b0;
    @(negedge clk); d = rd_data; rd_ch = 3'd7; rd_sel = 1'b1;
    chk(d == 8'h55, "R9 read ch1 reg0", d, 8'h55);
    @(negedge clk);
    chk(rd_data == 8'hC5, "R9 read ch7 reg1", rd_data, 8'hC5);
    // R10: result of ch5 must be intact despite flipped channel writes
    rd(3'd5, 1'b1, d);
    chk(d == 8'h01, "R10 ch5 reg1 intact", d, 8'h01);
    rd(3'd6, 1'b0, d);
    // R1: reset mid conversion
    @(negedge clk); res10 = 1'b1; ch_sel = 3'd6; vin = 10'h3FF; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (6) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && trial_code == 0, "R1 reset abandons", {busy, done, trial_code}, 0);
    rst = 1'b0;
    repeat (16) @(negedge clk);
    chk(busy == 0 && done == 0, "R1 stays idle", {busy, done}, 0);
    convert(1'b1, 3'd6, 10'h17B);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule